// File: doc/BRIEF.md
# Flash erase suspend command arbiter

This block is the command-side controller of a NOR-style flash device around a block erase. Bus writes arrive as a command byte together with a block address. The block starts an erase, suspends it, and while the erase is suspended it admits only a small set of commands. It drives an 8-bit status register, a busy output, a read-mode selector for the data path, and start and run controls to an abstracted erase/program engine.

A suspended erase leaves the bus free for two things: reading blocks other than the one being erased, and programming a word into some other block. Such a nested program is started with a one-cycle pulse to the engine and ends when the engine reports done. A resume command written while that program runs is held back. The erase restarts only after the program has finished. The engine is modelled purely by its handshakes (erase run level, erase done, program start pulse, program done).

Top module: `esa_top`

## Requirements
- R1: After reset the status register reads 8'h80 (bit 7 ready, all else 0), busy is 0, erase_run is 0 and rd_mode is 0 (array).
- R2: Command 8'h20 followed by 8'hD0 starts an erase of the block given with the second write. From the edge that takes the second write, erase_run is 1, erase_block holds that block, busy is 1, status bit 7 is 0 and rd_mode is 1 (status).
- R3: If the write after 8'h20 is any code other than 8'hD0, status bits 5 and 4 are both set, no erase starts and the block is idle again.
- R4: Command 8'hB0 written while erasing takes effect at that edge: erase_run drops to 0, status bit 6 (suspended) and bit 7 (ready) read 1, and busy is 0.
- R5: While suspended, 8'hFF sets rd_mode 0 (array), 8'h70 sets rd_mode 1 (status), 8'h98 sets rd_mode 2 (query), 8'hB8 sets rd_mode 3 (configure), and 8'h50 clears status bits 5 and 4.
- R6: While suspended, a code outside the set {FF, 70, 98, B8, 50, D0, 40, 10} is ignored. The state, the status register and rd_mode stay unchanged.
- R7: While suspended, 8'h40 or 8'h10 followed by a write to a block other than erase_block starts a nested program. prog_start is high for exactly one cycle with prog_block equal to that block, status bit 7 reads 0, status bit 6 stays 1 and busy is 1.
- R8: A nested program aimed at the suspended block is rejected. Status bit 4 is set, prog_start stays 0, and the block stays suspended with bit 7 at 1.
- R9: Resume (8'hD0) while suspended with no program running takes effect at that edge. erase_run is 1, status bits 7 and 6 are 0, busy is 1 and rd_mode is 1 (status).
- R10: A resume written during a nested program leaves erase_run at 0 until prog_done. At the edge that samples prog_done, the erase resumes with status bits 7 and 6 at 0. Without a pending resume, prog_done returns the block to the suspended state with bit 7 at 1.
- R11: erase_done while erasing returns the block to idle: status bit 7 reads 1, bit 6 reads 0, and busy and erase_run are 0.
- R12: busy is always the inverse of status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A bus command write is present this cycle |
| cmd_code | input | 8 | Command byte of the write |
| cmd_blk | input | BLK_W | Block address of the write |
| erase_done | input | 1 | Engine finished the erase |
| prog_done | input | 1 | Engine finished the nested program |
| erase_run | output | 1 | Engine may run the erase |
| erase_block | output | BLK_W | Block being erased |
| prog_start | output | 1 | One-cycle program start pulse |
| prog_block | output | BLK_W | Target block of the nested program |
| status | output | 8 | Status register (7 ready, 6 suspended, 5 sequence error, 4 program error) |
| busy | output | 1 | 1 while the engine is working |
| rd_mode | output | 2 | Read path select: 0 array, 1 status, 2 query, 3 configure |

## Verification
Every output is registered, and each one changes at the same clock edge that samples the causing write or done pulse. No result takes extra latency. The bench drives inputs on the falling edge and holds them for one cycle. It samples at the next falling edge, half a period after the edge that took the stimulus, so every check lands in the first cycle where the new value is due. For the held resume, the bench checks once in the cycle after the resume write, where nothing may change yet. It checks again in the cycle after prog_done, where the erase must be running. For prog_start, the bench samples the pulse in that first cycle and then confirms it is low one cycle later.

// File: rtl/esa_pkg.sv
package esa_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_RD_ARRAY  = 8'hFF;
    localparam logic [CMD_W-1:0] OP_RD_STATUS = 8'h70;
    localparam logic [CMD_W-1:0] OP_RD_QUERY  = 8'h98;
    localparam logic [CMD_W-1:0] OP_CONFIG    = 8'hB8;
    localparam logic [CMD_W-1:0] OP_CLEAR     = 8'h50;
    localparam logic [CMD_W-1:0] OP_ERS_SETUP = 8'h20;
    localparam logic [CMD_W-1:0] OP_CONFIRM   = 8'hD0;
    localparam logic [CMD_W-1:0] OP_SUSPEND   = 8'hB0;
    localparam logic [CMD_W-1:0] OP_PRG_A     = 8'h40;
    localparam logic [CMD_W-1:0] OP_PRG_B     = 8'h10;

    // status register bit positions
    localparam int SR_READY = 7;
    localparam int SR_SUSP  = 6;
    localparam int SR_SEQ   = 5;
    localparam int SR_PRG   = 4;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_QUERY  = 2'd2,
        RM_CONFIG = 2'd3
    } rdmode_t;

    typedef enum logic [3:0] {
        K_NONE,
        K_RD_ARRAY,
        K_RD_STATUS,
        K_RD_QUERY,
        K_CONFIG,
        K_CLEAR,
        K_ERS_SETUP,
        K_CONFIRM,
        K_SUSPEND,
        K_PRG_SETUP
    } kind_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ERS_SETUP,
        S_ERASING,
        S_SUSP,
        S_SUS_PSETUP,
        S_SUS_PROG
    } state_t;

    typedef struct packed {
        logic set_prg_err;
        logic set_seq_err;
        logic clr_err;
    } sr_ev_t;

    function automatic kind_t classify(input logic [CMD_W-1:0] c);
        kind_t k;
        case (c)
            OP_RD_ARRAY:       k = K_RD_ARRAY;
            OP_RD_STATUS:      k = K_RD_STATUS;
            OP_RD_QUERY:       k = K_RD_QUERY;
            OP_CONFIG:         k = K_CONFIG;
            OP_CLEAR:          k = K_CLEAR;
            OP_ERS_SETUP:      k = K_ERS_SETUP;
            OP_CONFIRM:        k = K_CONFIRM;
            OP_SUSPEND:        k = K_SUSPEND;
            OP_PRG_A, OP_PRG_B: k = K_PRG_SETUP;
            default:           k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic logic suspend_allows(input kind_t k);
        case (k)
            K_RD_ARRAY, K_RD_STATUS, K_RD_QUERY, K_CONFIG,
            K_CLEAR, K_CONFIRM, K_PRG_SETUP: return 1'b1;
            default:                         return 1'b0;
        endcase
    endfunction

    function automatic logic is_read_kind(input kind_t k);
        return (k == K_RD_ARRAY) || (k == K_RD_STATUS) ||
               (k == K_RD_QUERY) || (k == K_CONFIG);
    endfunction

    function automatic rdmode_t mode_for(input kind_t k, input rdmode_t cur);
        case (k)
            K_RD_ARRAY:  return RM_ARRAY;
            K_RD_STATUS: return RM_STATUS;
            K_RD_QUERY:  return RM_QUERY;
            K_CONFIG:    return RM_CONFIG;
            default:     return cur;
        endcase
    endfunction

endpackage

// File: rtl/esa_cmd_decode.sv
module esa_cmd_decode
    import esa_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             take,
    output kind_t            kind
);
    always_comb begin
        take = cmd_valid;
        kind = classify(cmd_code);
    end
endmodule

// File: rtl/esa_ctrl_fsm.sv
module esa_ctrl_fsm
    import esa_pkg::*;
#(
    parameter int BLK_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  kind_t            kind,
    input  logic [BLK_W-1:0] cmd_blk,
    input  logic             erase_done,
    input  logic             prog_done,
    output state_t           state,
    output sr_ev_t           ev,
    output logic             erase_run,
    output logic [BLK_W-1:0] erase_block,
    output logic             prog_start,
    output logic [BLK_W-1:0] prog_block,
    output logic             busy,
    output rdmode_t          rd_mode
);
    state_t           nxt;
    logic             pend_q, pend_n;
    rdmode_t          mode_n;
    logic             start_n;
    logic [BLK_W-1:0] pblk_n, eblk_n;
    logic             resume_now;

    always_comb begin
        nxt     = state;
        pend_n  = pend_q;
        mode_n  = rd_mode;
        start_n = 1'b0;
        pblk_n  = prog_block;
        eblk_n  = erase_block;
        ev      = '0;
        resume_now = 1'b0;
        case (state)
            S_IDLE: begin
                if (take) begin
                    if (is_read_kind(kind))      mode_n = mode_for(kind, rd_mode);
                    else if (kind == K_CLEAR)    ev.clr_err = 1'b1;
                    else if (kind == K_ERS_SETUP) nxt = S_ERS_SETUP;
                end
            end
            S_ERS_SETUP: begin
                if (take) begin
                    mode_n = RM_STATUS;
                    if (kind == K_CONFIRM) begin
                        nxt    = S_ERASING;
                        eblk_n = cmd_blk;
                    end else begin
                        ev.set_seq_err = 1'b1;
                        ev.set_prg_err = 1'b1;
                        nxt            = S_IDLE;
                    end
                end
            end
            S_ERASING: begin
                if (erase_done) begin
                    nxt = S_IDLE;
                end else if (take) begin
                    if (kind == K_SUSPEND) begin
                        nxt    = S_SUSP;
                        mode_n = RM_STATUS;
                    end else if (kind == K_RD_STATUS) begin
                        mode_n = RM_STATUS;
                    end
                end
            end
            S_SUSP: begin
                if (take && suspend_allows(kind)) begin
                    if (is_read_kind(kind)) begin
                        mode_n = mode_for(kind, rd_mode);
                    end else if (kind == K_CLEAR) begin
                        ev.clr_err = 1'b1;
                    end else if (kind == K_CONFIRM) begin
                        nxt    = S_ERASING;
                        mode_n = RM_STATUS;
                    end else begin
                        nxt = S_SUS_PSETUP;
                    end
                end
            end
            S_SUS_PSETUP: begin
                if (take) begin
                    mode_n = RM_STATUS;
                    if (cmd_blk == erase_block) begin
                        ev.set_prg_err = 1'b1;
                        nxt            = S_SUSP;
                    end else begin
                        start_n = 1'b1;
                        pblk_n  = cmd_blk;
                        pend_n  = 1'b0;
                        nxt     = S_SUS_PROG;
                    end
                end
            end
            S_SUS_PROG: begin
                resume_now = pend_q || (take && kind == K_CONFIRM);
                if (prog_done) begin
                    pend_n = 1'b0;
                    if (resume_now) begin
                        nxt    = S_ERASING;
                        mode_n = RM_STATUS;
                    end else begin
                        nxt = S_SUSP;
                    end
                end else if (take) begin
                    if (kind == K_CONFIRM)        pend_n = 1'b1;
                    else if (kind == K_RD_STATUS) mode_n = RM_STATUS;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            pend_q      <= 1'b0;
            rd_mode     <= RM_ARRAY;
            prog_start  <= 1'b0;
            prog_block  <= '0;
            erase_block <= '0;
            erase_run   <= 1'b0;
            busy        <= 1'b0;
        end else begin
            state       <= nxt;
            pend_q      <= pend_n;
            rd_mode     <= mode_n;
            prog_start  <= start_n;
            prog_block  <= pblk_n;
            erase_block <= eblk_n;
            erase_run   <= (nxt == S_ERASING);
            busy        <= (nxt == S_ERASING) || (nxt == S_SUS_PROG);
        end
    end
endmodule

// File: rtl/esa_status_reg.sv
module esa_status_reg
    import esa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  state_t     state,
    input  sr_ev_t     ev,
    output logic [7:0] status
);
    logic seq_err_q, prg_err_q;
    logic ready, susp;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_err_q <= 1'b0;
            prg_err_q <= 1'b0;
        end else begin
            if (ev.clr_err) begin
                seq_err_q <= 1'b0;
                prg_err_q <= 1'b0;
            end
            if (ev.set_seq_err) seq_err_q <= 1'b1;
            if (ev.set_prg_err) prg_err_q <= 1'b1;
        end
    end

    always_comb begin
        ready = !((state == S_ERASING) || (state == S_SUS_PROG));
        susp  = (state == S_SUSP) || (state == S_SUS_PSETUP) || (state == S_SUS_PROG);
        status           = '0;
        status[SR_READY] = ready;
        status[SR_SUSP]  = susp;
        status[SR_SEQ]   = seq_err_q;
        status[SR_PRG]   = prg_err_q;
    end
endmodule

// File: rtl/esa_top.sv
module esa_top
    import esa_pkg::*;
#(
    parameter int BLK_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic [BLK_W-1:0] cmd_blk,
    input  logic             erase_done,
    input  logic             prog_done,
    output logic             erase_run,
    output logic [BLK_W-1:0] erase_block,
    output logic             prog_start,
    output logic [BLK_W-1:0] prog_block,
    output logic [7:0]       status,
    output logic             busy,
    output logic [1:0]       rd_mode
);
    logic    take;
    kind_t   kind;
    state_t  cur_state;
    sr_ev_t  ev;
    rdmode_t mode_q;

    esa_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .take      (take),
        .kind      (kind)
    );

    esa_ctrl_fsm #(.BLK_W(BLK_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .take        (take),
        .kind        (kind),
        .cmd_blk     (cmd_blk),
        .erase_done  (erase_done),
        .prog_done   (prog_done),
        .state       (cur_state),
        .ev          (ev),
        .erase_run   (erase_run),
        .erase_block (erase_block),
        .prog_start  (prog_start),
        .prog_block  (prog_block),
        .busy        (busy),
        .rd_mode     (mode_q)
    );

    esa_status_reg u_sr (
        .clk    (clk),
        .rst    (rst),
        .state  (cur_state),
        .ev     (ev),
        .status (status)
    );

    assign rd_mode = mode_q;
endmodule

// File: rtl/esa_chk.sv
module esa_chk
    import esa_pkg::*;
#(
    parameter int BLK_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [7:0]       cmd_code,
    input logic             erase_done,
    input logic             erase_run,
    input logic [BLK_W-1:0] erase_block,
    input logic             prog_start,
    input logic [BLK_W-1:0] prog_block,
    input logic [7:0]       status,
    input logic             busy,
    input logic [1:0]       rd_mode,
    input state_t           cur_state
);
    assert_busy_mirror_R12: assert property (@(posedge clk) disable iff (rst)
        busy == !status[7]);

    assert_hold_erase_R10: assert property (@(posedge clk) disable iff (rst)
        status[6] |-> !erase_run);

    assert_prog_target_R8: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> (prog_block != erase_block));

    assert_prog_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        prog_start |=> !prog_start);

    assert_ignore_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_state == S_SUSP && cmd_valid && !suspend_allows(classify(cmd_code)))
        |=> ($stable(status) && $stable(rd_mode) && cur_state == S_SUSP));

    assert_resume_R9: assert property (@(posedge clk) disable iff (rst)
        (cur_state == S_SUSP && cmd_valid && classify(cmd_code) == K_CONFIRM)
        |=> (erase_run && status[7:6] == 2'b00 && rd_mode == 2'd1));

    assert_suspend_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_state == S_ERASING && !erase_done && cmd_valid &&
         classify(cmd_code) == K_SUSPEND)
        |=> (status[7:6] == 2'b11 && !erase_run && !busy));
endmodule

bind esa_top esa_chk #(.BLK_W(BLK_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .erase_done  (erase_done),
    .erase_run   (erase_run),
    .erase_block (erase_block),
    .prog_start  (prog_start),
    .prog_block  (prog_block),
    .status      (status),
    .busy        (busy),
    .rd_mode     (rd_mode),
    .cur_state   (cur_state)
);

// File: tb/sim_esa_top.sv
module sim_esa_top;
    localparam int CLK_P = 10;
    localparam int BW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = 8'h00;
    logic [BW-1:0] cmd_blk = '0;
    logic          erase_done = 1'b0;
    logic          prog_done = 1'b0;
    logic          erase_run, prog_start, busy;
    logic [BW-1:0] erase_block, prog_block;
    logic [7:0]    status;
    logic [1:0]    rd_mode;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    esa_top #(.BLK_W(BW)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_blk(cmd_blk), .erase_done(erase_done), .prog_done(prog_done),
        .erase_run(erase_run), .erase_block(erase_block), .prog_start(prog_start),
        .prog_block(prog_block), .status(status), .busy(busy), .rd_mode(rd_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one write held for one cycle; returns at the falling edge after the capturing edge
    task automatic wr(input logic [7:0] code, input logic [BW-1:0] blk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_blk = blk;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 8'h00;
    endtask

    task automatic pdone();
        @(negedge clk);
        prog_done = 1'b1;
        @(negedge clk);
        prog_done = 1'b0;
    endtask

    task automatic edone();
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
    endtask

    function automatic logic [1:0] exp_mode(input logic [7:0] c, input logic [1:0] cur);
        case (c)
            8'hFF: return 2'd0;
            8'h70: return 2'd1;
            8'h98: return 2'd2;
            8'hB8: return 2'd3;
            default: return cur;
        endcase
    endfunction

    function automatic logic [7:0] exp_status_susp(input logic [7:0] c, input logic [7:0] cur);
        if (c == 8'h50) return cur & 8'hCF;
        return cur;
    endfunction

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] pool [10];
        logic [1:0] m;
        logic [7:0] s;
        pool = '{8'hFF, 8'h70, 8'h98, 8'hB8, 8'h50, 8'h20, 8'hB0, 8'h00, 8'hA5, 8'h3C};
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 status", status, 8'h80);
        check("R1 busy", busy, 0);
        check("R1 erase_run", erase_run, 0);
        check("R1 rd_mode", rd_mode, 0);

        // R3 bad erase sequence
        wr(8'h20, 6'd1);
        wr(8'h70, 6'd1);
        check("R3 status", status, 8'hB0);
        check("R3 erase_run", erase_run, 0);
        wr(8'h50, 6'd0);
        check("R3 clear in idle", status, 8'h80);

        // R2 start erase block 5
        wr(8'h20, 6'd0);
        wr(8'hD0, 6'd5);
        check("R2 erase_run", erase_run, 1);
        check("R2 erase_block", erase_block, 5);
        check("R2 busy", busy, 1);
        check("R2 status", status, 8'h00);
        check("R2 rd_mode", rd_mode, 1);

        // R4 suspend
        wr(8'hB0, 6'd0);
        check("R4 status", status, 8'hC0);
        check("R4 erase_run", erase_run, 0);
        check("R4 busy", busy, 0);
        check("R12 busy vs sr7", busy, !status[7]);

        // R8 program into suspended block
        wr(8'h40, 6'd0);
        wr(8'hAA, 6'd5);
        check("R8 status", status, 8'hD0);
        check("R8 prog_start", prog_start, 0);

        // R5/R6 random commands while suspended
        m = rd_mode;
        s = status;
        for (int i = 0; i < 60; i++) begin
            logic [7:0] c;
            c = pool[$urandom_range(0, 9)];
            wr(c, 6'($urandom_range(0, 63)));
            m = exp_mode(c, m);
            s = exp_status_susp(c, s);
            check((c inside {8'hFF, 8'h70, 8'h98, 8'hB8, 8'h50}) ? "R5 mode" : "R6 mode", rd_mode, m);
            check((c inside {8'hFF, 8'h70, 8'h98, 8'hB8, 8'h50}) ? "R5 status" : "R6 status", status, s);
            check("R6 erase_run", erase_run, 0);
        end
        // directed R5 / R6
        wr(8'h98, 6'd0);
        check("R5 query", rd_mode, 2);
        wr(8'hFF, 6'd0);
        check("R5 array", rd_mode, 0);
        wr(8'h20, 6'd0);
        check("R6 erase setup ignored", status, s);
        check("R6 mode kept", rd_mode, 0);
        wr(8'h50, 6'd0);
        check("R5 clear", status, 8'hC0);

        // R7 nested program to block 9, resume during it (R10)
        wr(8'h10, 6'd0);
        wr(8'h5A, 6'd9);
        check("R7 prog_start", prog_start, 1);
        check("R7 prog_block", prog_block, 9);
        check("R7 status", status, 8'h40);
        check("R7 busy", busy, 1);
        @(negedge clk);
        check("R7 pulse one cycle", prog_start, 0);
        wr(8'hD0, 6'd0);
        check("R10 held erase_run", erase_run, 0);
        check("R10 held status", status, 8'h40);
        pdone();
        check("R10 resumed erase_run", erase_run, 1);
        check("R10 resumed status", status, 8'h00);
        check("R10 busy", busy, 1);
        check("R10 rd_mode", rd_mode, 1);

        // R10 no pending resume, then R9 plain resume
        wr(8'hB0, 6'd0);
        wr(8'h40, 6'd0);
        wr(8'h11, 6'd2);
        check("R7 second prog_block", prog_block, 2);
        pdone();
        check("R10 back to suspend", status, 8'hC0);
        check("R10 erase_run low", erase_run, 0);
        wr(8'hFF, 6'd0);
        wr(8'hD0, 6'd0);
        check("R9 erase_run", erase_run, 1);
        check("R9 status", status, 8'h00);
        check("R9 busy", busy, 1);
        check("R9 rd_mode", rd_mode, 1);

        // R11
        edone();
        check("R11 status", status, 8'h80);
        check("R11 busy", busy, 0);
        check("R11 erase_run", erase_run, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule